// File: doc/BRIEF.md
# SPI Burst Transmit-Queue Loader

This block is an SPI master that writes one variable-length packet into the transmit queue of a radio transceiver as a single burst access. A one-cycle `start_i` pulse captures the packet length and pulls chip select low. The block then holds the serial clock idle until the slave pulls its data-out line low to show it is ready. After that it shifts out a header byte, then the length byte, then the payload bytes. The header byte holds the queue address with the burst-write flag set. Payload bytes come from a byte-wide valid/ready stream.

Bytes follow each other with no extra serial-clock periods between them, so a burst of n bytes takes exactly n × 8 serial-clock periods. Data returned on the slave's data-out line during the burst is not used. The serial clock comes from the system clock through a half-period divider, `HALF_PERIOD` system cycles per phase.

The controller is a state machine with seven states:
- `ST_IDLE`: waits for start.
- `ST_WAIT_RDY`: chip select is low and the block waits for the slave to be ready.
- `ST_HEADER`, `ST_LENGTH`, `ST_PAYLOAD`: one state per kind of byte being shifted.
- `ST_TAIL`: a half-period hold before chip select rises.
- `ST_DONE`: the one-cycle completion state.

The state transitions are:
- idle→wait-ready on start.
- wait-ready→header when data-out reads low.
- header→length at the end of the header byte.
- length→payload or payload→payload at the end of a byte when the next payload byte is accepted.
- length→tail or payload→tail at the end of a byte when no payload remains, or when no payload byte is offered (an underrun).
- tail→done after a half period.
- done→idle.

Top module: `spi_burst_loader`

## Requirements
- R1: After reset, `spi_csn_o` is 1, `spi_sclk_o` is 0, and `busy_o`, `done_o`, `underrun_o` and `pay_ready_o` are all 0.
- R2: A `start_i` pulse seen in idle drives `spi_csn_o` low on the following clock edge. `busy_o` is 1 from that edge until the transaction returns to idle, and is 0 again afterwards.
- R3: While chip select is low and the slave has not yet driven `spi_miso_i` low, `spi_sclk_o` stays low.
- R4: Bytes go out MSB first in SPI mode 0: `spi_mosi_o` is stable while `spi_sclk_o` is high, and the slave samples it on the rising edge. The first byte is `FIFO_ADDR | 8'h40` with bit 7 forced to 0 (a write). With the default address 8'h3F this is 8'h7F.
- R5: The second byte equals the `len_i` value captured at start.
- R6: After the length byte, exactly `len_i` payload bytes are sent in the order they were accepted over the valid/ready handshake. With `len_i` = 0, no payload byte is sent.
- R7: Consecutive rising serial-clock edges within a transaction are exactly 2 × `HALF_PERIOD` system cycles apart, including across byte boundaries.
- R8: `pay_ready_o` is high for one cycle, in the high phase of the last bit of a byte, when more payload is due. If `pay_valid_i` is 0 then, no more bytes are sent, the transaction ends, and `underrun_o` is 1 in the same cycle as `done_o`.
- R9: `spi_csn_o` rises `HALF_PERIOD` cycles after the final falling serial-clock edge. `done_o` is high for exactly one cycle, which is the first cycle with chip select high.
- R10: A `start_i` pulse while `busy_o` is 1 is ignored: there is no second transaction and no second `done_o`.
- R11: `spi_sclk_o` is 0 whenever `spi_csn_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle request to begin a transaction |
| len_i | input | 8 | Packet length, sampled with `start_i` |
| pay_data_i | input | 8 | Payload byte |
| pay_valid_i | input | 1 | Payload byte is available |
| pay_ready_o | output | 1 | Payload byte is taken on this cycle if valid |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | One-cycle completion pulse |
| underrun_o | output | 1 | Completion was caused by a missing payload byte |
| spi_csn_o | output | 1 | Active-low chip select |
| spi_sclk_o | output | 1 | Serial clock, idles low |
| spi_mosi_o | output | 1 | Serial data to the slave |
| spi_miso_i | input | 1 | Serial data from the slave; low means ready |

## Verification
The burst is run with several packet shapes:
- A short packet with a pseudo-random payload and a long packet with alternating 0x00/0xFF bytes. These catch bit-order and shift errors.
- A zero-length packet. This isolates the path that goes straight from the length byte to the tail.
- A packet whose payload source runs dry partway through. This separates a clean ending from an underrun ending.

The readiness delay is varied from zero to many cycles to show that no clock edge leaks out before the slave is ready. A start request made during a burst shows whether the busy lockout holds. Rising-edge spacing measured across byte boundaries detects any inserted dead time.

// File: rtl/spi_burst_pkg.sv
package spi_burst_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT_RDY,
        ST_HEADER,
        ST_LENGTH,
        ST_PAYLOAD,
        ST_TAIL,
        ST_DONE
    } ld_state_e;

    localparam int unsigned BYTE_W = 8;
    localparam logic [BYTE_W-1:0] BURST_FLAG = 8'h40;
    localparam logic [BYTE_W-1:0] WRITE_MASK = 8'h7F;

endpackage

// File: rtl/spi_half_tick.sv
module spi_half_tick #(
    parameter int unsigned HALF_PERIOD = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    output logic tick_o
);
    localparam int unsigned CW = (HALF_PERIOD > 1) ? $clog2(HALF_PERIOD) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_PERIOD - 1);

    logic [CW-1:0] cnt_q;

    assign tick_o = en_i && (cnt_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!en_i || tick_o) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/spi_tx_shifter.sv
module spi_tx_shifter #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] load_data_i,
    input  logic         shift_i,
    output logic         bit_o,
    output logic         last_o
);
    localparam int unsigned IW = (W > 1) ? $clog2(W) : 1;
    localparam logic [IW-1:0] TOP = IW'(W - 1);

    logic [W-1:0]  sreg_q;
    logic [IW-1:0] idx_q;

    assign bit_o  = sreg_q[W-1];
    assign last_o = (idx_q == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sreg_q <= '0;
            idx_q  <= '0;
        end else if (load_i) begin
            sreg_q <= load_data_i;
            idx_q  <= TOP;
        end else if (shift_i) begin
            sreg_q <= {sreg_q[W-2:0], 1'b0};
            idx_q  <= idx_q - 1'b1;
        end
    end
endmodule

// File: rtl/spi_burst_loader.sv
module spi_burst_loader
    import spi_burst_pkg::*;
#(
    parameter int unsigned     HALF_PERIOD = 2,
    parameter logic [7:0]      FIFO_ADDR   = 8'h3F
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic [7:0] len_i,
    input  logic [7:0] pay_data_i,
    input  logic       pay_valid_i,
    output logic       pay_ready_o,
    output logic       busy_o,
    output logic       done_o,
    output logic       underrun_o,
    output logic       spi_csn_o,
    output logic       spi_sclk_o,
    output logic       spi_mosi_o,
    input  logic       spi_miso_i
);
    localparam logic [BYTE_W-1:0] HDR_BYTE = (FIFO_ADDR | BURST_FLAG) & WRITE_MASK;

    ld_state_e state_q, state_d;

    logic              csn_q;
    logic              sclk_q;
    logic              err_q;
    logic [BYTE_W-1:0] len_q;
    logic [BYTE_W-1:0] remain_q;

    logic tick;
    logic shifting;
    logic tick_en;
    logic fall_tick;
    logic byte_end;
    logic need_pay;
    logic accept;
    logic sh_load;
    logic sh_shift;
    logic sh_bit;
    logic sh_last;
    logic [BYTE_W-1:0] sh_data;

    assign shifting  = (state_q == ST_HEADER) || (state_q == ST_LENGTH) ||
                       (state_q == ST_PAYLOAD);
    assign tick_en   = shifting || (state_q == ST_TAIL);
    assign fall_tick = shifting && tick && sclk_q;
    assign byte_end  = fall_tick && sh_last;
    assign need_pay  = byte_end && (remain_q != '0) &&
                       ((state_q == ST_LENGTH) || (state_q == ST_PAYLOAD));
    assign accept    = need_pay && pay_valid_i;

    spi_half_tick #(.HALF_PERIOD(HALF_PERIOD)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (tick_en),
        .tick_o (tick)
    );

    always_comb begin
        sh_load  = 1'b0;
        sh_data  = '0;
        sh_shift = fall_tick && !sh_last;
        if ((state_q == ST_WAIT_RDY) && !spi_miso_i) begin
            sh_load = 1'b1;
            sh_data = HDR_BYTE;
        end else if ((state_q == ST_HEADER) && byte_end) begin
            sh_load = 1'b1;
            sh_data = len_q;
        end else if (accept) begin
            sh_load = 1'b1;
            sh_data = pay_data_i;
        end
    end

    spi_tx_shifter #(.W(BYTE_W)) u_shift (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (sh_load),
        .load_data_i (sh_data),
        .shift_i     (sh_shift),
        .bit_o       (sh_bit),
        .last_o      (sh_last)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (start_i) state_d = ST_WAIT_RDY;
            ST_WAIT_RDY: if (!spi_miso_i) state_d = ST_HEADER;
            ST_HEADER:   if (byte_end) state_d = ST_LENGTH;
            ST_LENGTH, ST_PAYLOAD: begin
                if (byte_end) state_d = accept ? ST_PAYLOAD : ST_TAIL;
            end
            ST_TAIL:     if (tick) state_d = ST_DONE;
            ST_DONE:     state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            csn_q    <= 1'b1;
            sclk_q   <= 1'b0;
            err_q    <= 1'b0;
            len_q    <= '0;
            remain_q <= '0;
        end else begin
            if ((state_q == ST_IDLE) && start_i) begin
                csn_q    <= 1'b0;
                err_q    <= 1'b0;
                len_q    <= len_i;
                remain_q <= len_i;
            end
            if ((state_q == ST_TAIL) && tick) csn_q <= 1'b1;
            if (shifting && tick) sclk_q <= !sclk_q;
            else if (!shifting) sclk_q <= 1'b0;
            if (accept) remain_q <= remain_q - 1'b1;
            if (need_pay && !pay_valid_i) err_q <= 1'b1;
        end
    end

    // Outputs
    always_comb begin
        busy_o      = (state_q != ST_IDLE);
        done_o      = (state_q == ST_DONE);
        underrun_o  = (state_q == ST_DONE) && err_q;
        pay_ready_o = need_pay;
        spi_csn_o   = csn_q;
        spi_sclk_o  = sclk_q;
        spi_mosi_o  = shifting ? sh_bit : 1'b0;
    end

    // Assertions
    assert_sclk_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        spi_csn_o |-> !spi_sclk_o);
    assert_no_clk_before_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT_RDY) |-> !spi_sclk_o);
    assert_busy_with_select_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !spi_csn_o |-> busy_o);
    assert_ready_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pay_ready_o |=> !pay_ready_o);
    assert_ready_high_phase_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pay_ready_o |-> spi_sclk_o);
    assert_underrun_with_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        underrun_o |-> done_o);
    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    assert_done_deselected_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> spi_csn_o);
    assert_mosi_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_sclk_o && $past(spi_sclk_o)) |-> $stable(spi_mosi_o));
endmodule

// File: tb/spi_burst_loader_bench.sv
module spi_burst_loader_bench;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 2;
    localparam logic [7:0] ADDR = 8'h3F;
    localparam logic [7:0] EXP_HDR = 8'h7F;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic [7:0] len_i = '0;
    logic [7:0] pay_data_i = '0;
    logic       pay_valid_i = 1'b0;
    logic       pay_ready_o, busy_o, done_o, underrun_o;
    logic       spi_csn_o, spi_sclk_o, spi_mosi_o;
    logic       spi_miso_i = 1'b1;

    int tests = 0;
    int fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_burst_loader #(.HALF_PERIOD(HALF), .FIFO_ADDR(ADDR)) u_spi_burst_loader (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .len_i(len_i),
        .pay_data_i(pay_data_i), .pay_valid_i(pay_valid_i), .pay_ready_o(pay_ready_o),
        .busy_o(busy_o), .done_o(done_o), .underrun_o(underrun_o),
        .spi_csn_o(spi_csn_o), .spi_sclk_o(spi_sclk_o), .spi_mosi_o(spi_mosi_o),
        .spi_miso_i(spi_miso_i)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Payload source
    logic [7:0] pay_q[$];
    bit took = 0;
    always @(negedge clk) begin
        logic [7:0] dummy;
        if (took) begin
            dummy = pay_q.pop_front();
            took = 0;
        end
        pay_valid_i = (pay_q.size() > 0);
        pay_data_i  = pay_valid_i ? pay_q[0] : 8'h00;
        if (pay_valid_i && pay_ready_o) took = 1;
    end

    // Behavioural slave / monitor, evaluated every cycle
    logic [7:0] got_q[$];
    int  cyc = 0;
    bit  prev_sclk = 0, prev_csn = 1, prev_mosi = 0;
    bit  rdy_seen = 0;
    int  last_rise = -1, last_fall = -1;
    logic [7:0] cur = 0;
    int  nbits = 0;
    int  done_cnt = 0, underrun_cnt = 0;
    int  viol_r3 = 0, viol_r4 = 0, viol_r7 = 0, viol_r9 = 0, viol_r11 = 0;

    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (prev_csn && !spi_csn_o) begin
                rdy_seen = 0; last_rise = -1; last_fall = -1; nbits = 0;
            end
            if (!spi_csn_o && !spi_miso_i) rdy_seen = 1;
            if (spi_csn_o && spi_sclk_o) viol_r11++;
            if (!spi_csn_o && !rdy_seen && spi_sclk_o) viol_r3++;
            if (spi_sclk_o && prev_sclk && spi_mosi_o != prev_mosi) viol_r4++;
            if (spi_sclk_o && !prev_sclk) begin
                if (last_rise >= 0 && cyc - last_rise != 2*HALF) viol_r7++;
                last_rise = cyc;
                cur = {cur[6:0], spi_mosi_o};
                nbits++;
                if (nbits == 8) begin got_q.push_back(cur); nbits = 0; end
            end
            if (!spi_sclk_o && prev_sclk) last_fall = cyc;
            if (!prev_csn && spi_csn_o) begin
                if (last_fall >= 0 && cyc - last_fall != HALF) viol_r9++;
                if (!done_o) viol_r9++;
            end
            if (done_o) begin
                done_cnt++;
                if (underrun_o) underrun_cnt++;
            end
        end
        prev_sclk = spi_sclk_o; prev_csn = spi_csn_o; prev_mosi = spi_mosi_o;
    end

    task automatic run_txn(input int len, input int navail, input int pattern,
                           input int miso_delay, input bit mid_start);
        logic [7:0] exp_q[$];
        int npay;
        int waited;
        npay = (navail < len) ? navail : len;
        exp_q.push_back(EXP_HDR);
        exp_q.push_back(8'(len));
        pay_q.delete();
        for (int i = 0; i < navail; i++) begin
            logic [7:0] b;
            b = (pattern == 0) ? 8'(8'h5A ^ (i * 37 + 3)) : ((i % 2) ? 8'hFF : 8'h00);
            pay_q.push_back(b);
            if (i < npay) exp_q.push_back(b);
        end
        got_q.delete();
        done_cnt = 0; underrun_cnt = 0;
        viol_r3 = 0; viol_r4 = 0; viol_r7 = 0; viol_r9 = 0; viol_r11 = 0;

        @(posedge clk); #1;
        check(spi_csn_o == 1 && busy_o == 0, "R2 idle before start", int'(busy_o), 0);
        spi_miso_i = 1; len_i = 8'(len); start_i = 1;
        @(posedge clk); #1;
        start_i = 0;
        check(spi_csn_o == 0, "R2 csn low after start", int'(spi_csn_o), 0);
        check(busy_o == 1, "R2 busy after start", int'(busy_o), 1);
        repeat (miso_delay) @(posedge clk);
        #1 spi_miso_i = 0;
        if (mid_start) begin
            repeat (12) @(posedge clk);
            #1 start_i = 1;
            @(posedge clk); #1 start_i = 0;
        end
        waited = 0;
        while (done_cnt == 0 && waited < 5000) begin
            @(posedge clk); waited++;
        end
        check(waited < 5000, "R9 transaction completes", waited, 0);
        #1 spi_miso_i = 1;
        repeat (30) @(posedge clk);
        #1;
        check(done_cnt == 1, "R9/R10 single done pulse", done_cnt, 1);
        check(spi_csn_o == 1 && busy_o == 0, "R2/R10 back to idle", int'(busy_o), 0);
        check(got_q.size() == exp_q.size(), "R6 byte count", got_q.size(), exp_q.size());
        for (int i = 0; i < exp_q.size() && i < got_q.size(); i++) begin
            if (i == 0)      check(got_q[i] == exp_q[i], "R4 header byte", got_q[i], exp_q[i]);
            else if (i == 1) check(got_q[i] == exp_q[i], "R5 length byte", got_q[i], exp_q[i]);
            else             check(got_q[i] == exp_q[i], "R6 payload byte", got_q[i], exp_q[i]);
        end
        check(underrun_cnt == ((navail < len) ? 1 : 0), "R8 underrun flag",
              underrun_cnt, (navail < len) ? 1 : 0);
        check(viol_r3 == 0, "R3 no clock before ready", viol_r3, 0);
        check(viol_r4 == 0, "R4 mosi stable in high phase", viol_r4, 0);
        check(viol_r7 == 0, "R7 gapless edge spacing", viol_r7, 0);
        check(viol_r9 == 0, "R9 csn rise timing", viol_r9, 0);
        check(viol_r11 == 0, "R11 sclk idle low", viol_r11, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check(spi_csn_o == 1 && spi_sclk_o == 0, "R1 reset bus idle", int'(spi_sclk_o), 0);
        check(busy_o == 0 && done_o == 0 && underrun_o == 0 && pay_ready_o == 0,
              "R1 reset flags", int'(busy_o), 0);
        rst_n = 1;
        run_txn(3, 3, 0, 4, 0);
        run_txn(0, 0, 0, 0, 0);
        run_txn(6, 6, 1, 2, 1);
        run_txn(5, 2, 0, 3, 0);
        run_txn(2, 2, 0, 25, 0);
        run_txn(12, 12, 0, 1, 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule